// File: doc/BRIEF.md
# Interrupt Message Vector Table Controller

This block keeps a small table of interrupt message vectors and a bit array of pending vectors, both reachable through a 4 KB register window. Each vector's table entry holds a message address, message data and a control word with a per-vector mask. When the device raises an interrupt request for a vector, the block either sends that vector's address and data as one message write or records the request as pending.

A pending vector is not forgotten. Writing to any word of its table entry schedules a re-check of that vector. If the re-check finds the vector pending and no longer masked, the message goes out. Software clears a vector's mask through the register port, and the deferred interrupt is then delivered.

Messages leave through a single-entry output register with a valid/ready handshake. The parameter `NUM_VEC` sets the number of vectors, from 1 to 128.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, every table word and every pending bit reads as zero and `msg_valid` is low.
- R2: Vector v's entry starts at offset 16*v. Its words are: address low at +0x0, address high at +0x4, data at +0x8 and control at +0xC. A full-word write is returned by a read of the same offset, and the read data appears on `reg_rdata` the cycle after `reg_rd`. Offsets below 0x800 that belong to no implemented vector read as zero and ignore writes.
- R3: An access with `reg_word` low is a non-32-bit access. Such a write changes nothing, and such a read returns zero.
- R4: The pending array starts at offset 0x800. Vector v's flag is bit (v mod 32) of the word at 0x800 + 4*(v/32). Writes at offsets 0x800 and above are discarded.
- R5: A request is ignored in any of three cases: `irq_level` is low, `fn_enable` is low, or `irq_vec` is not below `NUM_VEC`. In each case no message is sent and no pending flag changes.
- R6: An accepted request is deferred when either `fn_mask` is set or bit 0 of the vector's control word is set. A deferred request sets the vector's pending flag and sends no message.
- R7: An accepted, unmasked request made while the output is empty loads a message on the next clock edge and clears the vector's pending flag. The message address is {address high, address low with bits 1:0 forced to zero}, and the message data is the vector's data word.
- R8: While `msg_valid` is high and `msg_ready` is low, the message stays valid and its address and data stay unchanged. A cycle with `msg_ready` high empties the output.
- R9: A full-word write to a vector's table entry schedules a re-check of that vector, carried out in the next cycle in which the output is empty and no request fires. A re-check of a pending vector sends its message and clears its flag if four conditions hold: the vector is unmasked, `fn_enable` is set, `fn_mask` is clear, and the output is empty. A newer table write replaces a re-check still waiting.
- R10: An accepted, unmasked request made while the output is still occupied sets the vector's pending flag instead of being lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_word | input | 1 | Access is a full 32-bit word |
| reg_addr | input | 12 | Window offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_req | input | 1 | Interrupt request strobe |
| irq_level | input | 1 | Request level; only high is acted on |
| irq_vec | input | 7 | Vector index of the request |
| fn_enable | input | 1 | Global enable of message generation |
| fn_mask | input | 1 | Function-wide mask |
| msg_valid | output | 1 | Message is present |
| msg_ready | input | 1 | Consumer takes the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions assume that `irq_req`, `reg_wr` and `msg_ready` are driven to known values from the first clock edge. They also assume that a request and a waiting re-check may arrive in the same cycle, so each pending-flag property excludes cycles where a re-check is waiting. The bench drives one request or one register access at a time, always on the falling edge. It holds `msg_ready` high except in the backpressure test, so no two message sources compete in a way the checks do not model.

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl #(
  parameter int NUM_VEC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic        reg_word,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        irq_req,
  input  logic        irq_level,
  input  logic [6:0]  irq_vec,
  input  logic        fn_enable,
  input  logic        fn_mask,
  output logic        msg_valid,
  input  logic        msg_ready,
  output logic [63:0] msg_addr,
  output logic [31:0] msg_data
);
  localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;
  localparam int PW = (NUM_VEC + 31) / 32;

  logic [31:0] t_lo [NUM_VEC];
  logic [31:0] t_hi [NUM_VEC];
  logic [31:0] t_dat[NUM_VEC];
  logic [31:0] t_ctl[NUM_VEC];
  logic [NUM_VEC-1:0] pend;
  logic [PW*32-1:0]   pend_pad;

  logic          chk_v;
  logic [VW-1:0] chk_vec;

  wire [6:0]    wvec   = reg_addr[10:4];
  wire [VW-1:0] wv     = wvec[VW-1:0];
  wire          w_in   = !reg_addr[11] && ({25'd0, wvec} < NUM_VEC);
  wire          tbl_we = reg_wr && reg_word && w_in;

  wire [VW-1:0] iv        = irq_vec[VW-1:0];
  wire          irq_ok    = irq_req && irq_level && fn_enable && ({25'd0, irq_vec} < NUM_VEC);
  wire          irq_mskd  = fn_mask || t_ctl[iv][0];
  wire          out_free  = !msg_valid;
  wire          irq_fire  = irq_ok && !irq_mskd && out_free;
  wire          irq_defer = irq_ok && (irq_mskd || !out_free);

  wire chk_go   = chk_v && out_free && !irq_fire;
  wire chk_fire = chk_go && pend[chk_vec] && !t_ctl[chk_vec][0] && fn_enable && !fn_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        t_lo[i]  <= '0;
        t_hi[i]  <= '0;
        t_dat[i] <= '0;
        t_ctl[i] <= '0;
      end
    end else if (tbl_we) begin
      case (reg_addr[3:2])
        2'd0: t_lo[wv]  <= reg_wdata;
        2'd1: t_hi[wv]  <= reg_wdata;
        2'd2: t_dat[wv] <= reg_wdata;
        default: t_ctl[wv] <= reg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      if (irq_defer) pend[iv] <= 1'b1;
      if (irq_fire)  pend[iv] <= 1'b0;
      if (chk_fire)  pend[chk_vec] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v   <= 1'b0;
      chk_vec <= '0;
    end else if (tbl_we) begin
      chk_v   <= 1'b1;
      chk_vec <= wv;
    end else if (chk_go) begin
      chk_v   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (irq_fire) begin
      msg_valid <= 1'b1;
      msg_addr  <= {t_hi[iv], t_lo[iv][31:2], 2'b00};
      msg_data  <= t_dat[iv];
    end else if (chk_fire) begin
      msg_valid <= 1'b1;
      msg_addr  <= {t_hi[chk_vec], t_lo[chk_vec][31:2], 2'b00};
      msg_data  <= t_dat[chk_vec];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_VEC-1:0] = pend;
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (reg_word) begin
      if (reg_addr[11]) begin
        if ({23'd0, reg_addr[10:2]} < PW)
          rd_val = pend_pad[32*reg_addr[10:2] +: 32];
      end else if (w_in) begin
        case (reg_addr[3:2])
          2'd0: rd_val = t_lo[wv];
          2'd1: rd_val = t_hi[wv];
          2'd2: rd_val = t_dat[wv];
          default: rd_val = t_ctl[wv];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  // R8
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R6
  fn_mask_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ok && fn_mask && !msg_valid && !chk_v |=> !msg_valid && pend[$past(iv)]);

  // R5
  low_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_level && !chk_v |=> $stable(pend));

  // R4
  pba_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr[11] && !irq_req && !chk_v |=> $stable(pend));

  // R7 R9
  msg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(irq_req || chk_v));
endmodule

// File: tb/msix_vec_ctrl_test.sv
module msix_vec_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_word = 1;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_req = 0, irq_level = 0;
  logic [6:0] irq_vec = '0;
  logic fn_enable = 0, fn_mask = 0, msg_ready = 1;
  logic msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  msix_vec_ctrl #(.NUM_VEC(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_word(reg_word),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vec(irq_vec),
    .fn_enable(fn_enable), .fn_mask(fn_mask), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data));

  function automatic logic [31:0] lo_of(int v);  return 32'h1000_0003 | (v << 4); endfunction
  function automatic logic [31:0] hi_of(int v);  return 32'h0000_0F00 + v; endfunction
  function automatic logic [31:0] dat_of(int v); return 32'hD000_0000 + v; endfunction
  function automatic logic [63:0] exp_addr(int v); return {hi_of(v), lo_of(v) & 32'hFFFF_FFFC}; endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit w);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_word = w; reg_wr = 1;
    @(negedge clk); reg_wr = 0; reg_word = 1;
  endtask

  task automatic rdchk(input logic [11:0] a, input bit w, input logic [31:0] exp, input string tag);
    @(negedge clk); reg_addr = a; reg_word = w; reg_rd = 1;
    @(negedge clk); reg_rd = 0; reg_word = 1;
    check(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic irq(input int v, input bit lvl);
    @(negedge clk); irq_vec = 7'(v); irq_level = lvl; irq_req = 1;
    @(negedge clk); irq_req = 0;
  endtask

  task automatic msgchk(input int v, input string tag);
    check(msg_valid === 1'b1, {tag, " valid"}, 64'(msg_valid), 64'd1);
    check(msg_addr == exp_addr(v), {tag, " addr"}, msg_addr, exp_addr(v));
    check(msg_data == dat_of(v), {tag, " data"}, 64'(msg_data), 64'(dat_of(v)));
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check(msg_valid == 0, "R1 msg_valid", 64'(msg_valid), 0);
    for (int v = 0; v < 8; v++)
      for (int w = 0; w < 4; w++)
        rdchk(12'(16*v + 4*w), 1, 0, "R1 table zero");
    rdchk(12'h800, 1, 0, "R1 pending zero");

    // R2: table layout and read-back sweep; odd vectors masked
    for (int v = 0; v < 8; v++) begin
      wr(12'(16*v),     lo_of(v), 1);
      wr(12'(16*v + 4), hi_of(v), 1);
      wr(12'(16*v + 8), dat_of(v), 1);
      wr(12'(16*v + 12), 32'h0000_AB00 | (v & 1), 1);
    end
    for (int v = 0; v < 8; v++) begin
      rdchk(12'(16*v),      1, lo_of(v), "R2 addr low");
      rdchk(12'(16*v + 4),  1, hi_of(v), "R2 addr high");
      rdchk(12'(16*v + 8),  1, dat_of(v), "R2 data");
      rdchk(12'(16*v + 12), 1, 32'h0000_AB00 | (v & 1), "R2 control");
    end
    wr(12'h080, 32'h1234_5678, 1);
    rdchk(12'h080, 1, 0, "R2 unimplemented entry");
    wr(12'h7F0, 32'h1234_5678, 1);
    rdchk(12'h7F0, 1, 0, "R2 top of table area");

    // R3: non-word accesses
    wr(12'h000, 32'hFFFF_FFFF, 0);
    rdchk(12'h000, 1, lo_of(0), "R3 narrow write ignored");
    rdchk(12'h000, 0, 0, "R3 narrow read zero");

    // R5: enable low, level low, out of range
    irq(0, 1);
    check(msg_valid == 0, "R5 disabled", 64'(msg_valid), 0);
    fn_enable = 1;
    irq(2, 0);
    check(msg_valid == 0, "R5 low level", 64'(msg_valid), 0);
    irq(9, 1);
    check(msg_valid == 0, "R5 out of range", 64'(msg_valid), 0);
    rdchk(12'h800, 1, 0, "R5 pending untouched");

    // R6 R7: request sweep over all vectors
    for (int v = 0; v < 8; v++) begin
      irq(v, 1);
      if (v % 2 == 0) msgchk(v, "R7 unmasked request");
      else check(msg_valid == 0, "R6 masked no message", 64'(msg_valid), 0);
      @(negedge clk);
    end
    rdchk(12'h800, 1, 32'h0000_00AA, "R6 pending of masked vectors");
    rdchk(12'h800, 0, 0, "R3 narrow pending read");
    fn_mask = 1;
    irq(0, 1);
    check(msg_valid == 0, "R6 function mask", 64'(msg_valid), 0);
    rdchk(12'h800, 1, 32'h0000_00AB, "R6 function mask sets pending");
    fn_mask = 0;
    irq(0, 1);
    msgchk(0, "R7 pending cleared by send");
    rdchk(12'h800, 1, 32'h0000_00AA, "R7 pending bit cleared");

    // R4: pending array is read-only
    wr(12'h800, 32'hFFFF_FFFF, 1);
    wr(12'h804, 32'hFFFF_FFFF, 1);
    rdchk(12'h800, 1, 32'h0000_00AA, "R4 pending write discarded");

    // R9: unmask vector 1 through a table write
    wr(12'h01C, 32'h0, 1);
    @(negedge clk);
    msgchk(1, "R9 recheck fires");
    rdchk(12'h800, 1, 32'h0000_00A8, "R9 pending cleared");
    wr(12'h014, hi_of(2), 1);
    @(negedge clk);
    check(msg_valid == 0, "R9 recheck of idle vector", 64'(msg_valid), 0);

    // R8 R10: backpressure
    msg_ready = 0;
    irq(0, 1);
    msgchk(0, "R8 first message");
    irq(2, 1);
    rdchk(12'h800, 1, 32'h0000_00AC, "R10 busy output defers");
    repeat (3) @(negedge clk);
    msgchk(0, "R8 held while not ready");
    msg_ready = 1;
    @(negedge clk);
    check(msg_valid == 0, "R8 drained", 64'(msg_valid), 0);
    wr(12'h02C, 32'h0, 1);
    @(negedge clk);
    msgchk(2, "R9 deferred vector delivered");
    rdchk(12'h800, 1, 32'h0000_00A8, "R9 pending after delivery");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule